// File: doc/BRIEF.md
# Dual-Path Programmable Clock Generator

The block derives one output clock from four source clocks under the control of a single 32-bit configuration word. It contains two identical branches. Each branch picks one source, divides it by an integer, and gates it. A final glitch-free switch then hands the output to one branch or the other. Because of this, software can retune the branch that is not driving the output, flip one bit, and move the output over without any runt pulse. Three of the sources are fixed fractions of a common PLL (/4, /3 and /5). The fourth source is chosen at build time: either a /7 of the same PLL or an independent general-purpose PLL. Both give the same selector code.

A build-time option removes the second branch and the switch. In that variant, the gated output of branch 0 is the block output, and the branch-select bit and all branch-1 fields have no effect. The configuration word is loaded through a simple write-enable port clocked by `cfg_clk`. Fields are expected to be changed only while their branch is idle or gated off.

Top module: `dpclk_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, the configuration word is zero and `clk_out` stays low with no rising edge.
- R2: On a rising `cfg_clk` edge with `cfg_we` high, the configuration word takes the value of `cfg_wdata`.
- R3: The 2-bit source code of a branch maps as follows: 0 = `src_div4`, 1 = `src_div3`, 2 = `src_div5`, 3 = the fourth source.
- R4: With `ALT_FOURTH` = 0, code 3 selects `src_div7`. With `ALT_FOURTH` = 1, code 3 selects `src_gp`.
- R5: A 7-bit divide field N makes the branch period N+1 times the selected source period (range /1 to /128). N = 0 passes the source through.
- R6: The branch 0 fields are: divide N at bits [6:0], gate enable at bit 8, source code at bits [10:9]. The branch 1 fields are: divide at [22:16], gate enable at bit 24, source code at [26:25]. When the gate enable of the active branch is 0, `clk_out` stays low.
- R7: Bit 31 selects the output branch (0 = branch 0, 1 = branch 1). While it changes, no `clk_out` high or low phase is shorter than half the period of the faster of the two branches.
- R8: Rewriting the source, divide and gate fields of the idle branch leaves the period and pulse widths of `clk_out` unchanged.
- R9: With `DUAL_PATH` = 0, `clk_out` follows branch 0 regardless of bit 31 and the branch-1 fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Clock of the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the configuration word |
| cfg_wdata | input | 32 | Configuration word to load |
| src_div4 | input | 1 | Source clock, fixed PLL /4 (code 0) |
| src_div3 | input | 1 | Source clock, fixed PLL /3 (code 1) |
| src_div5 | input | 1 | Source clock, fixed PLL /5 (code 2) |
| src_div7 | input | 1 | Fourth source when ALT_FOURTH = 0 |
| src_gp | input | 1 | Fourth source when ALT_FOURTH = 1 |
| clk_out | output | 1 | Generated clock |

## Verification
The bench measures output periods over every source code with several divide values, including pass-through and the /128 limit. A divider that counts N instead of N+1, or a swapped selector code, shows up as a wrong period. Branch switches in both directions and idle-branch retuning run with a pulse-width monitor, so a switch that enables the new branch on the wrong edge, or an idle branch that leaks through, produces a short phase. Gated-off branches must show no edges at all, which catches a gate that passes runts. A second instance built as the single-branch variant with the alternate fourth source must ignore the branch-select bit.

// File: rtl/dpclk_pkg.sv
package dpclk_pkg;
  localparam int REG_W = 32;
  localparam int DIV_W = 7;
  localparam int SEL_W = 2;

  localparam int B0_DIV_LSB  = 0;
  localparam int B0_GATE_BIT = 8;
  localparam int B0_SEL_LSB  = 9;
  localparam int B1_DIV_LSB  = 16;
  localparam int B1_GATE_BIT = 24;
  localparam int B1_SEL_LSB  = 25;
  localparam int OUT_SEL_BIT = 31;

  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic             gate;
    logic [DIV_W-1:0] div;
  } branch_cfg_t;

  function automatic branch_cfg_t unpack_branch(input logic [REG_W-1:0] word,
                                                input int div_lsb,
                                                input int gate_bit,
                                                input int sel_lsb);
    branch_cfg_t c;
    c.div  = word[div_lsb +: DIV_W];
    c.gate = word[gate_bit];
    c.src  = word[sel_lsb +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/dpclk_rst_sync.sv
module dpclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dpclk_branch.sv
module dpclk_branch
  import dpclk_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int SW = SEL_W,
  localparam int NSRC = 1 << SW
) (
  input  logic            arst_n,
  input  logic [NSRC-1:0] src_clk,
  input  logic [SW-1:0]   src_sel,
  input  logic [DW-1:0]   div_n,
  input  logic            gate_en,
  output logic            gclk,
  output logic            brst_n
);
  logic          mclk;
  logic [DW-1:0] cnt_q, cnt_d, half;
  logic          div_q, div_d;
  logic          dclk;
  logic          en_lat;

  // Source selection
  assign mclk = src_clk[src_sel];

  dpclk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (mclk),
    .arst_n (arst_n),
    .rst_n_o(brst_n)
  );

  // Integer divider: period N+1, high for the first floor(N/2)+1 counts
  assign half = div_n >> 1;

  always_comb begin
    cnt_d = (cnt_q >= div_n) ? '0 : cnt_q + 1'b1;
    div_d = (cnt_d <= half);
  end

  always_ff @(posedge mclk or negedge brst_n) begin
    if (!brst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign dclk = (div_n == '0) ? mclk : div_q;

  // Latch-based gate: enable captured only while the clock is low
  always_latch begin
    if (!dclk) en_lat = gate_en;
  end

  assign gclk = dclk & en_lat;

  // R6: a gate held off across a full cycle yields no high phase
  a_r6_gate_low: assert property (@(negedge dclk) disable iff (!brst_n)
    (!gate_en && $past(!gate_en)) |-> !gclk)
    else $error("gated branch produced a high phase");
endmodule

// File: rtl/dpclk_switch.sv
module dpclk_switch #(
  parameter int LANES  = 2,
  parameter int SYNC_N = 2
) (
  input  logic [LANES-1:0] clk_in,
  input  logic [LANES-1:0] rst_in_n,
  input  logic             pick_b,
  output logic             clk_o
);
  logic [LANES-1:0] en_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic req;
    logic s1_q, en_q;

    // Request this lane only when selected and the other lane is off
    assign req = (pick_b == 1'(i)) & ~en_v[LANES-1-i];

    always_ff @(posedge clk_in[i] or negedge rst_in_n[i]) begin
      if (!rst_in_n[i]) s1_q <= 1'b0;
      else              s1_q <= req;
    end

    // Second stage on the falling edge: enable changes only while low
    always_ff @(negedge clk_in[i] or negedge rst_in_n[i]) begin
      if (!rst_in_n[i]) en_q <= 1'b0;
      else              en_q <= s1_q;
    end

    assign en_v[i] = en_q;
  end

  assign clk_o = |(clk_in & en_v);

  // R7: never two lanes driving the output together
  a_r7_exclusive: assert property (@(posedge clk_in[0])
    disable iff (!rst_in_n[0] || !rst_in_n[1])
    $onehot0(en_v))
    else $error("both switch lanes enabled");
endmodule

// File: rtl/dpclk_gen.sv
module dpclk_gen
  import dpclk_pkg::*;
#(
  parameter bit DUAL_PATH  = 1'b1,
  parameter bit ALT_FOURTH = 1'b0
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             src_div4,
  input  logic             src_div3,
  input  logic             src_div5,
  input  logic             src_div7,
  input  logic             src_gp,
  output logic             clk_out
);
  localparam int NSRC = 1 << SEL_W;

  logic             cfg_rst_n;
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             fourth_clk;
  logic [NSRC-1:0]  srcs;
  branch_cfg_t      cfg0;
  logic             g0, brst0_n;

  dpclk_rst_sync #(.STAGES(2)) u_cfg_rst (
    .clk    (cfg_clk),
    .arst_n (rst_n),
    .rst_n_o(cfg_rst_n)
  );

  // Configuration word
  always_comb ctrl_d = cfg_we ? cfg_wdata : ctrl_q;

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  // Fourth source variant
  if (ALT_FOURTH) begin : g_fourth_gp
    logic unused_src;
    assign fourth_clk = src_gp;
    assign unused_src = src_div7;
  end else begin : g_fourth_div7
    logic unused_src;
    assign fourth_clk = src_div7;
    assign unused_src = src_gp;
  end

  assign srcs = {fourth_clk, src_div5, src_div3, src_div4};
  assign cfg0 = unpack_branch(ctrl_q, B0_DIV_LSB, B0_GATE_BIT, B0_SEL_LSB);

  dpclk_branch #(.DW(DIV_W), .SW(SEL_W)) u_branch0 (
    .arst_n (rst_n),
    .src_clk(srcs),
    .src_sel(cfg0.src),
    .div_n  (cfg0.div),
    .gate_en(cfg0.gate),
    .gclk   (g0),
    .brst_n (brst0_n)
  );

  if (DUAL_PATH) begin : g_dual
    branch_cfg_t cfg1;
    logic        g1, brst1_n;
    logic        unused_bits;

    assign cfg1 = unpack_branch(ctrl_q, B1_DIV_LSB, B1_GATE_BIT, B1_SEL_LSB);

    dpclk_branch #(.DW(DIV_W), .SW(SEL_W)) u_branch1 (
      .arst_n (rst_n),
      .src_clk(srcs),
      .src_sel(cfg1.src),
      .div_n  (cfg1.div),
      .gate_en(cfg1.gate),
      .gclk   (g1),
      .brst_n (brst1_n)
    );

    dpclk_switch #(.LANES(2), .SYNC_N(2)) u_switch (
      .clk_in  ({g1, g0}),
      .rst_in_n({brst1_n, brst0_n}),
      .pick_b  (ctrl_q[OUT_SEL_BIT]),
      .clk_o   (clk_out)
    );

    assign unused_bits = ^{ctrl_q[30:27], ctrl_q[23], ctrl_q[15:11], ctrl_q[7]};
  end else begin : g_single
    logic unused_bits;
    assign clk_out     = g0;
    assign unused_bits = ^{ctrl_q[31:11], ctrl_q[7], brst0_n};
  end

  // R2: write port loads the word on the next edge
  a_r2_write: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfg_we |=> (ctrl_q == $past(cfg_wdata)))
    else $error("configuration write lost");

  // R1: output quiet while the register domain is in reset
  always @(posedge cfg_clk) begin
    if (!cfg_rst_n) begin
      a_r1_quiet_in_reset: assert (!clk_out)
        else $error("clock output active during reset");
    end
  end
endmodule

// File: tb/dpclk_gen_test.sv
`timescale 1ns/1ps
module dpclk_gen_test;
  logic        cfg_clk, rst_n, cfg_we;
  logic [31:0] cfg_wdata;
  logic        s4, s3, s5, s7, sgp;
  logic        out_d, out_s;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 0;

  // cfg_clk at 50 MHz, offset so its edges never coincide with source edges
  initial begin cfg_clk = 0; #0.25; forever #10 cfg_clk = ~cfg_clk; end
  initial begin s4  = 0; forever #5  s4  = ~s4;  end
  initial begin s3  = 0; forever #7  s3  = ~s3;  end
  initial begin s5  = 0; forever #9  s5  = ~s5;  end
  initial begin s7  = 0; forever #13 s7  = ~s7;  end
  initial begin sgp = 0; forever #11 sgp = ~sgp; end

  dpclk_gen #(.DUAL_PATH(1'b1), .ALT_FOURTH(1'b0)) uut (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .src_div4(s4), .src_div3(s3), .src_div5(s5), .src_div7(s7), .src_gp(sgp),
    .clk_out(out_d));

  dpclk_gen #(.DUAL_PATH(1'b0), .ALT_FOURTH(1'b1)) uut_lone (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .src_div4(s4), .src_div3(s3), .src_div5(s5), .src_div7(s7), .src_gp(sgp),
    .clk_out(out_s));

  // Edge bookkeeping
  int      rise_d = 0, rise_s = 0;
  realtime last_d = 0, prev_d = 0, last_s = 0, prev_s = 0;
  realtime edge_d = 0, minw = 1.0e9;
  bit      armed = 0;

  always @(posedge out_d) begin prev_d = last_d; last_d = $realtime; rise_d++; end
  always @(posedge out_s) begin prev_s = last_s; last_s = $realtime; rise_s++; end
  always @(out_d) begin
    if (armed && ($realtime - edge_d) < minw) minw = $realtime - edge_d;
    edge_d = $realtime;
  end

  function automatic real src_per(int s, bit alt);
    case (s)
      0: return 10.0;
      1: return 14.0;
      2: return 18.0;
      default: return alt ? 22.0 : 26.0;
    endcase
  endfunction

  function automatic logic [31:0] cw(int s0, int n0, bit e0, int s1, int n1, bit e1, bit o);
    logic [31:0] w;
    w = '0;
    w[6:0]   = n0[6:0];
    w[8]     = e0;
    w[10:9]  = s0[1:0];
    w[22:16] = n1[6:0];
    w[24]    = e1;
    w[26:25] = s1[1:0];
    w[31]    = o;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge cfg_clk); cfg_we = 1; cfg_wdata = d;
    @(negedge cfg_clk); cfg_we = 0;
  endtask

  task automatic measure(input bit lone, input real exp, output real per);
    int  c0;
    real waited;
    c0 = lone ? rise_s : rise_d;
    waited = 0;
    while (((lone ? rise_s : rise_d) < c0 + 3) && waited < 6*exp + 500) begin
      #1; waited += 1;
    end
    if ((lone ? rise_s : rise_d) >= c0 + 3) per = lone ? (last_s - prev_s) : (last_d - prev_d);
    else per = 0.0;
  endtask

  task automatic check_period(input string req, input bit lone, input real exp);
    real per;
    measure(lone, exp, per);
    chk((per > exp - 0.01) && (per < exp + 0.01), req, per, exp);
  endtask

  task automatic check_silent(input string req, input bit lone);
    int c0;
    c0 = lone ? rise_s : rise_d;
    #500;
    chk(((lone ? rise_s : rise_d) == c0) && ((lone ? out_s : out_d) === 1'b0),
        req, real'((lone ? rise_s : rise_d) - c0), 0.0);
  endtask

  task automatic arm(); minw = 1.0e9; armed = 1; endtask

  initial begin
    #3_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int nlist[5] = '{0, 1, 2, 3, 6};
    rst_n = 0; cfg_we = 0; cfg_wdata = '0;
    #100;
    // R1: reset state
    chk(out_d === 1'b0, "R1", real'(out_d), 0.0);
    chk(out_s === 1'b0, "R1", real'(out_s), 0.0);
    @(negedge cfg_clk); rst_n = 1;
    repeat (4) @(negedge cfg_clk);
    check_silent("R1", 1'b0);
    check_silent("R1", 1'b1);

    // R2/R3/R4/R5: branch 0 sweep over every source code and several divides
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) begin
        real ed, es;
        ed = src_per(s, 1'b0) * (nlist[k] + 1);
        es = src_per(s, 1'b1) * (nlist[k] + 1);
        wr(cw(s, nlist[k], 1, 0, 0, 0, 0));
        #(3*es + 300);
        check_period((k == 0) ? "R3" : "R5", 1'b0, ed);
        check_period((s == 3) ? "R4" : "R2", 1'b1, es);
      end
    end

    // R5: largest divide
    wr(cw(0, 127, 1, 0, 0, 0, 0));
    #4200;
    check_period("R5", 1'b0, 1280.0);

    // R6: gate off on the active branch
    wr(cw(0, 0, 0, 0, 0, 0, 0));
    #300;
    check_silent("R6", 1'b0);
    check_silent("R6", 1'b1);

    // R6/R7: prepare branch 1 while idle, then switch
    wr(cw(0, 0, 1, 2, 1, 1, 0));
    #600;
    check_period("R6", 1'b0, 10.0);
    arm();
    wr(cw(0, 0, 1, 2, 1, 1, 1));
    #1200;
    armed = 0;
    chk(minw >= 5.0 - 0.01, "R7", minw, 5.0);
    check_period("R7", 1'b0, 36.0);
    check_period("R9", 1'b1, 10.0);

    // R8: retune idle branch 0 while branch 1 drives the output
    arm();
    wr(cw(0, 0, 0, 2, 1, 1, 1)); #300;
    wr(cw(3, 3, 0, 2, 1, 1, 1)); #300;
    wr(cw(3, 3, 1, 2, 1, 1, 1)); #600;
    armed = 0;
    chk(minw >= 18.0 - 0.01, "R8", minw, 18.0);
    check_period("R8", 1'b0, 36.0);
    check_period("R9", 1'b1, 88.0);

    // R7: switch back to retuned branch 0
    arm();
    wr(cw(3, 3, 1, 2, 1, 1, 0));
    #1500;
    armed = 0;
    chk(minw >= 18.0 - 0.01, "R7", minw, 18.0);
    check_period("R7", 1'b0, 104.0);

    // R6: new branch 1 fields, then switch to it
    wr(cw(3, 3, 1, 1, 3, 1, 0));
    #600;
    arm();
    wr(cw(3, 3, 1, 1, 3, 1, 1));
    #1500;
    armed = 0;
    chk(minw >= 28.0 - 0.01, "R7", minw, 28.0);
    check_period("R6", 1'b0, 56.0);

    // R6: gating the active branch 1 silences the output; R9: lone ignores it
    wr(cw(3, 3, 1, 1, 3, 0, 1));
    #300;
    check_silent("R6", 1'b0);
    check_period("R9", 1'b1, 88.0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule